// File: doc/BRIEF.md
# Signal Reliability Gate Evaluator

This block computes how probability and correctness travel through a single faulty two-input logic gate. Each input signal arrives as a four-entry probability vector. The entries are the chances that the signal is a correct 0, a wrong 1, a wrong 0 or a correct 1. The block forms all sixteen pairings of the two input states. For each pairing it evaluates the selected gate twice: once on the observed values and once on the values the inputs would carry without error. A per-gate correctness probability `q` then splits each pairing's weight between the gate's expected output and its inverted output. The result is the output signal's own four-entry vector, plus that signal's reliability, which is the probability that it is correct.

All probabilities are unsigned Q1.15 fixed point, where 1.0 is 0x8000. The gate type and `q` are supplied with every operand set, so back-to-back requests may use different gates. The block has a valid/ready handshake on both sides and a fixed pipeline latency. When the output is blocked, the whole pipeline stalls.

Top module: `sig_rel_gate`

## Requirements
- R1: A vector port packs four Q1.15 entries, with entry k at bits [16k+15:16k]. Entry 0 is P(correct 0), entry 1 is P(wrong 1), entry 2 is P(wrong 0) and entry 3 is P(correct 1). 0x8000 represents 1.0.
- R2: For state index k, the observed value is bit 0 of k and the error-free value is bit 1 of k. An output lands in entry {error-free result, observed result}.
- R3: Output entry {t,v} is the sum, over all 16 input pairs (i,j), of a_i·b_j weighted by q when v equals the gate applied to the observed values, or by 1−q otherwise. Only pairs whose error-free gate result equals t contribute. The sum is rounded to nearest once and saturates at 0x8000.
- R4: Gate select codes are 0 AND, 1 OR, 2 NAND, 3 NOR, 4 XOR and 5 XNOR. Codes 6 and 7 give the same result as AND.
- R5: A `q` above 0x8000 is treated as exactly 1.0, and 1−q is formed as 0x8000 − q.
- R6: `out_rel` equals entry 0 plus entry 3 of the output vector, saturated at 0x8000.
- R7: An operand set accepted on clock edge n, with `out_ready` held high, shows `out_valid` high after edge n+4 and for exactly one cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_vec` and `out_rel` hold their values.
- R9: After reset settles, `in_ready` equals `!out_valid || out_ready`. One operand set can be accepted per cycle, and results leave in acceptance order.
- R10: While `rst_n` is low, `out_valid` and `in_ready` are 0. `in_ready` rises within two cycles after release.
- R11: A NAND with q = 0x75C3 (0.92) and both inputs at {0x4000,0,0,0x4000} yields about {0.23, 0.02, 0.06, 0.69} ({7537, 655, 1966, 22610}) and reliability 0.92 (30147).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Block can take an operand set this cycle |
| in_gate | input | 3 | Gate function select |
| in_q | input | 16 | Gate correctness probability, Q1.15 |
| in_a | input | 64 | First input probability vector |
| in_b | input | 64 | Second input probability vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vec | output | 64 | Output probability vector |
| out_rel | output | 16 | Output reliability |

## Verification
The assertions assume that a consumer samples results only through the handshake. They also assume that the sixteen joint products of 16-bit entries fit the bin width, which holds for any input value. Because the output-bound properties rely only on saturation, no assumption about whether the input vectors are normalised is needed. The stimulus keeps vector entries summing to at most 1.0, with one exception: a deliberate case with every entry at 1.0 drives the saturation path. The stimulus sweeps `q` across 0, 1.0 and values above 1.0. It also toggles `out_ready` at random, so that stalls land while the pipeline is both full and partially filled.

// File: rtl/sig_rel_pkg.sv
package sig_rel_pkg;
  // number of correctness states carried per signal
  localparam int ST_N    = 4;
  // bit of a state index holding the observed level
  localparam int OBS_BIT = 0;
  // bit of a state index holding the error-free level
  localparam int REF_BIT = 1;

  localparam logic [2:0] GSEL_AND  = 3'd0;
  localparam logic [2:0] GSEL_OR   = 3'd1;
  localparam logic [2:0] GSEL_NAND = 3'd2;
  localparam logic [2:0] GSEL_NOR  = 3'd3;
  localparam logic [2:0] GSEL_XOR  = 3'd4;
  localparam logic [2:0] GSEL_XNOR = 3'd5;

  function automatic logic gate_apply(input logic [2:0] sel, input logic x, input logic y);
    logic r;
    case (sel)
      GSEL_OR:   r = x | y;
      GSEL_NAND: r = ~(x & y);
      GSEL_NOR:  r = ~(x | y);
      GSEL_XOR:  r = x ^ y;
      GSEL_XNOR: r = ~(x ^ y);
      default:   r = x & y;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/srg_kron.sv
module srg_kron
  import sig_rel_pkg::*;
#(
  parameter int DW = 16,
  localparam int PW = 2 * DW,
  localparam int NJ = ST_N * ST_N
)(
  input  logic                         clk,
  input  logic                         arst_n,
  input  logic                         en,
  input  logic [ST_N-1:0][DW-1:0]      a_i,
  input  logic [ST_N-1:0][DW-1:0]      b_i,
  output logic [NJ-1:0][PW-1:0]        j_o
);
  logic [NJ-1:0][PW-1:0] j_d;

  // full-precision outer product, pair (ia, ib) at index ia*ST_N+ib
  for (genvar ia = 0; ia < ST_N; ia++) begin : g_row
    for (genvar ib = 0; ib < ST_N; ib++) begin : g_col
      assign j_d[ia*ST_N+ib] = PW'(a_i[ia]) * PW'(b_i[ib]);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  j_o <= '0;
    else if (en)  j_o <= j_d;
  end
endmodule

// File: rtl/srg_bin.sv
module srg_bin
  import sig_rel_pkg::*;
#(
  parameter int DW = 16,
  localparam int PW = 2 * DW,
  localparam int NJ = ST_N * ST_N,
  localparam int BW = PW + $clog2(NJ)
)(
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic                    en,
  input  logic [2:0]              gate_i,
  input  logic [NJ-1:0][PW-1:0]   j_i,
  output logic [ST_N-1:0][BW-1:0] bin_o
);
  logic [ST_N-1:0][BW-1:0] bin_d;
  logic [1:0] sa, sb;
  logic       f_obs, f_ref;

  // bin index is {error-free result, observed result}
  always_comb begin
    bin_d = '0;
    sa    = '0;
    sb    = '0;
    f_obs = 1'b0;
    f_ref = 1'b0;
    for (int k = 0; k < NJ; k++) begin
      sa    = 2'(k / ST_N);
      sb    = 2'(k % ST_N);
      f_obs = gate_apply(gate_i, sa[OBS_BIT], sb[OBS_BIT]);
      f_ref = gate_apply(gate_i, sa[REF_BIT], sb[REF_BIT]);
      bin_d[{f_ref, f_obs}] = bin_d[{f_ref, f_obs}] + BW'(j_i[k]);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  bin_o <= '0;
    else if (en)  bin_o <= bin_d;
  end
endmodule

// File: rtl/srg_weight.sv
module srg_weight
  import sig_rel_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 15,
  localparam int PW  = 2 * DW,
  localparam int BW  = PW + $clog2(ST_N * ST_N),
  localparam int MW  = BW + DW + 1,
  localparam int SH  = 2 * FRAC
)(
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic                    en,
  input  logic [DW-1:0]           q_i,
  input  logic [ST_N-1:0][BW-1:0] bin_i,
  output logic [ST_N-1:0][DW-1:0] y_o
);
  localparam logic [DW-1:0] ONE = DW'(1) << FRAC;
  localparam logic [MW-1:0] RND = MW'(1) << (SH - 1);

  logic [DW-1:0]           nq;
  logic [ST_N-1:0][DW-1:0] y_d;

  assign nq = ONE - q_i;

  // entry v draws from bin v at q and from bin v^1 (same reference, other observed level) at 1-q
  for (genvar v = 0; v < ST_N; v++) begin : g_ent
    logic [MW-1:0] acc;
    logic [MW-1:0] rnd;
    assign acc    = MW'(bin_i[v]) * MW'(q_i) + MW'(bin_i[v ^ 1]) * MW'(nq);
    assign rnd    = (acc + RND) >> SH;
    assign y_d[v] = (rnd > MW'(ONE)) ? ONE : rnd[DW-1:0];
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  y_o <= '0;
    else if (en)  y_o <= y_d;
  end

  // R5
  q_clamped_chk: assert property (@(posedge clk) disable iff (!arst_n) en |-> (q_i <= ONE));
endmodule

// File: rtl/sig_rel_gate.sv
module sig_rel_gate
  import sig_rel_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 15
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_gate,
  input  logic [DW-1:0]   in_q,
  input  logic [4*DW-1:0] in_a,
  input  logic [4*DW-1:0] in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [4*DW-1:0] out_vec,
  output logic [DW-1:0]   out_rel
);
  localparam int PW    = 2 * DW;
  localparam int NJ    = ST_N * ST_N;
  localparam int BW    = PW + $clog2(NJ);
  localparam int NSTG  = 5;
  localparam logic [DW-1:0] ONE = DW'(1) << FRAC;

  // reset release synchroniser
  logic [1:0] rsync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  // pipeline occupancy, global stall when the last rank is blocked
  logic [NSTG-1:0] vld_q, vld_d;
  logic            adv;
  assign adv = !vld_q[NSTG-1] || out_ready;

  always_comb begin
    vld_d = vld_q;
    if (adv) vld_d = {vld_q[NSTG-2:0], in_valid & arst_n};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  assign in_ready  = adv & arst_n;
  assign out_valid = vld_q[NSTG-1];

  // rank 1: operand capture
  logic [ST_N-1:0][DW-1:0] a1_q, b1_q;
  logic [2:0]              g1_q;
  logic [DW-1:0]           q1_q, q_cl;
  logic                    en1;
  assign en1  = adv & in_valid & arst_n;
  assign q_cl = (in_q > ONE) ? ONE : in_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      a1_q <= '0;
      b1_q <= '0;
      g1_q <= '0;
      q1_q <= '0;
    end else if (en1) begin
      a1_q <= in_a;
      b1_q <= in_b;
      g1_q <= in_gate;
      q1_q <= q_cl;
    end
  end

  // rank 2: joint distribution
  logic                  en2;
  logic [NJ-1:0][PW-1:0] j2;
  logic [2:0]            g2_q;
  logic [DW-1:0]         q2_q;
  assign en2 = adv & vld_q[0];

  srg_kron #(.DW(DW)) u_kron (
    .clk(clk), .arst_n(arst_n), .en(en2),
    .a_i(a1_q), .b_i(b1_q), .j_o(j2)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      g2_q <= '0;
      q2_q <= '0;
    end else if (en2) begin
      g2_q <= g1_q;
      q2_q <= q1_q;
    end
  end

  // rank 3: classification into four bins
  logic                    en3;
  logic [ST_N-1:0][BW-1:0] bin3;
  logic [DW-1:0]           q3_q;
  assign en3 = adv & vld_q[1];

  srg_bin #(.DW(DW)) u_bin (
    .clk(clk), .arst_n(arst_n), .en(en3),
    .gate_i(g2_q), .j_i(j2), .bin_o(bin3)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  q3_q <= '0;
    else if (en3) q3_q <= q2_q;
  end

  // rank 4: gate error weighting
  logic                    en4;
  logic [ST_N-1:0][DW-1:0] y4;
  assign en4 = adv & vld_q[2];

  srg_weight #(.DW(DW), .FRAC(FRAC)) u_wgt (
    .clk(clk), .arst_n(arst_n), .en(en4),
    .q_i(q3_q), .bin_i(bin3), .y_o(y4)
  );

  // rank 5: output and reliability
  logic          en5;
  logic [DW:0]   rel_sum;
  logic [DW-1:0] rel_d;
  assign en5     = adv & vld_q[3];
  assign rel_sum = {1'b0, y4[0]} + {1'b0, y4[ST_N-1]};
  assign rel_d   = (rel_sum > {1'b0, ONE}) ? ONE : rel_sum[DW-1:0];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      out_vec <= '0;
      out_rel <= '0;
    end else if (en5) begin
      out_vec <= y4;
      out_rel <= rel_d;
    end
  end

  // checking aids
  logic [BW+1:0] jtot, btot;
  always_comb begin
    jtot = '0;
    for (int k = 0; k < NJ; k++) jtot = jtot + (BW+2)'(j2[k]);
    btot = '0;
    for (int k = 0; k < ST_N; k++) btot = btot + (BW+2)'(bin3[k]);
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_rel)));

  // R9
  blocked_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R3
  bin_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && vld_q[1]) |=> (btot == $past(jtot)));

  // R3
  entry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_vec[DW-1:0] <= ONE && out_vec[2*DW-1:DW] <= ONE &&
                   out_vec[3*DW-1:2*DW] <= ONE && out_vec[4*DW-1:3*DW] <= ONE));

  // R6
  rel_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_rel <= ONE && out_rel >= out_vec[DW-1:0] && out_rel >= out_vec[4*DW-1:3*DW]));

  // R7
  latency_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> vld_q[0]);
endmodule

// File: tb/sig_rel_gate_tb.sv
`timescale 1ns/1ps
module sig_rel_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_gate = '0;
  logic [15:0] in_q = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_vec;
  logic [15:0] out_rel;

  always #4 clk = ~clk;

  sig_rel_gate u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_gate(in_gate), .in_q(in_q), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec), .out_rel(out_rel)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cur_tag = 0;
  bit live = 0;
  bit done = 0;

  typedef struct {
    int e0; int e1; int e2; int e3; int er; int due; int tag;
  } exp_t;
  exp_t pend[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input int tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic bit near(input int a, input int b);
    return (a - b) <= 2 && (b - a) <= 2;
  endfunction

  // R4: codes 0..5 AND OR NAND NOR XOR XNOR, 6 and 7 as AND
  function automatic bit gfun(input int g, input bit x, input bit y);
    case (g)
      1: return x | y;
      2: return !(x & y);
      3: return !(x | y);
      4: return x ^ y;
      5: return !(x ^ y);
      default: return x & y;
    endcase
  endfunction

  function automatic real cap1(input real v);
    return (v > 1.0) ? 1.0 : v;
  endfunction

  // R1/R2/R3/R5/R6 behavioural reference in real arithmetic
  function automatic exp_t model(input int g, input int qr, input logic [63:0] a, input logic [63:0] b, input int tag);
    real qq;
    real y[4];
    exp_t r;
    qq = real'((qr > 32768) ? 32768 : qr) / 32768.0;
    for (int k = 0; k < 4; k++) y[k] = 0.0;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        real p;
        int fo, ft;
        p  = real'(a[16*i +: 16]) * real'(b[16*j +: 16]) / 1073741824.0;
        fo = int'(gfun(g, i[0], j[0]));
        ft = int'(gfun(g, i[1], j[1]));
        y[ft*2 + fo]       += p * qq;
        y[ft*2 + (1 - fo)] += p * (1.0 - qq);
      end
    end
    r.e0  = $rtoi(cap1(y[0]) * 32768.0 + 0.5);
    r.e1  = $rtoi(cap1(y[1]) * 32768.0 + 0.5);
    r.e2  = $rtoi(cap1(y[2]) * 32768.0 + 0.5);
    r.e3  = $rtoi(cap1(y[3]) * 32768.0 + 0.5);
    r.er  = $rtoi(cap1(cap1(y[0]) + cap1(y[3])) * 32768.0 + 0.5);
    r.due = 0;
    r.tag = tag;
    return r;
  endfunction

  // per-cycle comparison against the reference queue
  logic [63:0] hv;
  logic [15:0] hr;
  bit was_stall = 0;
  always @(negedge clk) begin
    if (rst_n && live && !done) begin
      bit   expv;
      exp_t t;
      expv = (pend.size() > 0) && (pend[0].due <= cyc);
      // R7 exact arrival cycle
      chk(out_valid == expv, 7, "out_valid timing", int'(out_valid), int'(expv));
      // R9
      chk(in_ready == (!out_valid || out_ready), 9, "in_ready", int'(in_ready), int'(!out_valid || out_ready));
      if (was_stall) begin
        // R8
        chk(out_vec == hv && out_rel == hr, 8, "held result", int'(out_vec[31:0]), int'(hv[31:0]));
      end
      if (out_valid && expv) begin
        t = pend[0];
        chk(near(int'(out_vec[15:0]),  t.e0), t.tag, "entry0", int'(out_vec[15:0]),  t.e0);
        chk(near(int'(out_vec[31:16]), t.e1), t.tag, "entry1", int'(out_vec[31:16]), t.e1);
        chk(near(int'(out_vec[47:32]), t.e2), t.tag, "entry2", int'(out_vec[47:32]), t.e2);
        chk(near(int'(out_vec[63:48]), t.e3), t.tag, "entry3", int'(out_vec[63:48]), t.e3);
        // R6
        chk(near(int'(out_rel), t.er), 6, "reliability", int'(out_rel), t.er);
        if (out_ready) void'(pend.pop_front());
      end
      was_stall = out_valid && !out_ready;
      hv = out_vec;
      hr = out_rel;
      if (was_stall) foreach (pend[k]) pend[k].due++;
      if (in_valid && in_ready) begin
        t = model(int'(in_gate), int'(in_q), in_a, in_b, cur_tag);
        t.due = cyc + 5;
        pend.push_back(t);
      end
    end
  end

  function automatic logic [63:0] mk(input int s0, input int s1, input int s2, input int s3);
    return {16'(s3), 16'(s2), 16'(s1), 16'(s0)};
  endfunction

  function automatic logic [63:0] rvec();
    return mk(int'($urandom % 8193), int'($urandom % 8193), int'($urandom % 8193), int'($urandom % 8193));
  endfunction

  task automatic send(input int g, input int qv, input logic [63:0] a, input logic [63:0] b);
    in_gate  = 3'(g);
    in_q     = 16'(qv);
    in_a     = a;
    in_b     = b;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, 10, "out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b0, 10, "in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(in_ready == 1'b1, 10, "in_ready after release", int'(in_ready), 1);
    chk(out_valid == 1'b0, 10, "out_valid after release", int'(out_valid), 0);
    live = 1;

    // R11 NAND example
    cur_tag = 11;
    send(2, 30147, mk(16384, 0, 0, 16384), mk(16384, 0, 0, 16384));
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    chk(near(int'(out_vec[15:0]), 7537),   11, "nand c0", int'(out_vec[15:0]), 7537);
    chk(near(int'(out_vec[31:16]), 655),   11, "nand w1", int'(out_vec[31:16]), 655);
    chk(near(int'(out_vec[47:32]), 1966),  11, "nand w0", int'(out_vec[47:32]), 1966);
    chk(near(int'(out_vec[63:48]), 22610), 11, "nand c1", int'(out_vec[63:48]), 22610);
    chk(near(int'(out_rel), 30147),        11, "nand rel", int'(out_rel), 30147);
    @(posedge clk);
    #1;

    // R2 wrong-state inputs land in the right entries
    cur_tag = 2;
    send(0, 32768, mk(0, 32768, 0, 0), mk(0, 0, 0, 32768));
    send(4, 32768, mk(0, 0, 32768, 0), mk(32768, 0, 0, 0));
    send(1, 20000, mk(0, 16384, 16384, 0), mk(8192, 8192, 8192, 8192));
    repeat (8) @(posedge clk);
    #1;

    // R4 every gate code, R1 packing through random vectors
    cur_tag = 4;
    for (int g = 0; g < 8; g++) begin
      for (int n = 0; n < 6; n++) send(g, int'($urandom % 32769), rvec(), rvec());
    end
    repeat (8) @(posedge clk);
    #1;

    // R5 q boundaries and q above 1.0
    cur_tag = 5;
    send(3, 0,     rvec(), rvec());
    send(3, 32768, rvec(), rvec());
    send(5, 65535, rvec(), rvec());
    send(2, 36864, rvec(), rvec());
    repeat (8) @(posedge clk);
    #1;

    // R3 saturation with every entry at 1.0
    cur_tag = 3;
    send(0, 32768, mk(32768, 32768, 32768, 32768), mk(32768, 32768, 32768, 32768));
    send(4, 16384, mk(32768, 32768, 32768, 32768), mk(32768, 32768, 32768, 32768));
    repeat (8) @(posedge clk);
    #1;

    // R9 back-to-back throughput
    cur_tag = 9;
    for (int n = 0; n < 20; n++) send(int'($urandom % 8), int'($urandom % 32769), rvec(), rvec());
    repeat (8) @(posedge clk);
    #1;

    // R8 stalls with random consumer
    cur_tag = 8;
    fork
      begin
        for (int n = 0; n < 30; n++) send(int'($urandom % 8), int'($urandom % 32769), rvec(), rvec());
      end
      begin
        repeat (200) begin
          @(posedge clk);
          #1;
          out_ready = 1'($urandom % 2);
        end
      end
    join
    @(posedge clk);
    #1;
    out_ready = 1'b1;

    // R7 isolated request latency
    cur_tag = 7;
    send(1, 30000, rvec(), rvec());
    repeat (20) @(posedge clk);
    #1;
    chk(pend.size() == 0, 9, "results drained", pend.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule